// File: doc/BRIEF.md
# Edge Flag Contour Generator

This block writes the outline of a filled shape into a one-bit working plane so that a later left-to-right parity pass can fill it. It takes one straight edge at a time, given as two integer endpoints, and for every scanline the edge crosses it inverts exactly one bit of the plane. Integer coordinates name the grid lines between pixels. Pixel (a,b) is the pixel just right of and above grid point (a,b). Scanline y is sampled at height y + 0.5.

The edge is walked from its lower endpoint to its upper one using integer difference arithmetic only. A column position and a remainder are carried from one scanline to the next, and the remainder is brought back into range one unit step per cycle. There is no multiply, no divide, and no stored edge list. Each toggle is a read followed by a write of the inverse, through a simple synchronous single-bit memory port. The work done is set by the outline length, not the enclosed area. A host presents an edge with a one-cycle `start` while the block is idle, then waits for the one-cycle `done`.

Top module: `eflag_contour`

## Requirements
- R1: During and straight after reset, `busy`, `done`, `mem_rd` and `mem_wr` are all low.
- R2: For each scanline y with min(y0,y1) <= y < max(y0,y1), the inverted pixel is column p = floor(x + 0.5), where x is the edge's x at height y + 0.5. This is the left-most pixel whose centre lies strictly right of the crossing. The pixel is in row y, and its memory address is row * 512 + column, with the row in the upper 9 bits and the column in the lower 9 bits.
- R3: Every toggle reads the addressed bit in one cycle. In the very next cycle it writes the inverse of the returned bit to the same address. The read data is valid in the cycle after `mem_rd`. Applying the same edge twice leaves the plane unchanged.
- R4: An edge spanning n scanlines issues at most n toggles, one per scanline, in rising row order. It issues exactly n when every computed column is on screen.
- R5: The result does not depend on the order in which the two endpoints are given.
- R6: An edge with y0 == y1 makes no memory access, and `done` is high in the cycle right after the accepting `start`.
- R7: A computed column of 512 or more produces no access for that scanline. A negative column would be clamped to column 0.
- R8: `done` is high for exactly one cycle, after the last write of the edge. In the following cycle `busy` is low.
- R9: `busy` is high from the cycle after an accepted `start` until `done`. A `start` seen while busy is ignored and does not change the edge being walked.
- R10: A read and a write never occur in the same cycle. A write is never followed directly by a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Accept the endpoints when idle |
| x0 | input | 10 | First endpoint x, 0..512 |
| y0 | input | 10 | First endpoint y, 0..512 |
| x1 | input | 10 | Second endpoint x, 0..512 |
| y1 | input | 10 | Second endpoint y, 0..512 |
| busy | output | 1 | An edge is being walked |
| done | output | 1 | One-cycle pulse at edge completion |
| mem_addr | output | 18 | Plane bit address {row, column} |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wbit | output | 1 | Bit written |
| mem_rbit | input | 1 | Bit read, valid the cycle after `mem_rd` |

## Verification
The assertions watch the port discipline on every cycle:
- each read is followed by a write to the same address;
- a read and a write never coincide, and a write is never directly followed by a read;
- `done` lasts one cycle and returns the block to idle;
- a flat edge finishes at once;
- a read only happens when the remainder is settled and the column is on screen.

Only the bench scenarios can show that the chosen column matches the half-pixel crossing rule, that the off-screen and reversed-endpoint cases behave, that a repeated edge restores the plane, and that a `start` during a walk is ignored. For these, the logged toggles are compared against an arithmetic model of each edge.

// File: rtl/efc_pkg.sv
// Shared types for the edge flag contour generator.
package efc_pkg;
    // Control states of the edge walker.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_NORM,
        ST_READ,
        ST_WRITE,
        ST_STEP,
        ST_FIN
    } efc_state_e;
endpackage

// File: rtl/efc_order.sv
// Orders an edge so it runs upward, and derives its rise and signed run.
// Assumes both endpoints lie in 0..2^CW-1; purely combinational.
module efc_order #(
    parameter int CW = 10
) (
    input  logic                 [CW-1:0] x0,
    input  logic                 [CW-1:0] y0,
    input  logic                 [CW-1:0] x1,
    input  logic                 [CW-1:0] y1,
    output logic                 [CW-1:0] lo_x,
    output logic                 [CW-1:0] lo_y,
    output logic                 [CW-1:0] rise,
    output logic signed          [CW:0]   run,
    output logic                          flat
);
    logic [CW-1:0] hi_x, hi_y;

    // Pick the lower endpoint as the walk origin.
    always_comb begin
        if (y1 < y0) begin
            lo_x = x1; lo_y = y1; hi_x = x0; hi_y = y0;
        end else begin
            lo_x = x0; lo_y = y0; hi_x = x1; hi_y = y1;
        end
        rise = hi_y - lo_y;
        run  = $signed({1'b0, hi_x}) - $signed({1'b0, lo_x});
        flat = (rise == '0);
    end
endmodule

// File: rtl/efc_walker.sv
// Incremental edge stepper. Holds the pixel column and a remainder such that
// column*2*rise + rem = 2*rise*x_lo + rise + run*(2k+1) for scanline k.
// The column is valid once rem lies in [0, 2*rise). Each adjust moves the
// column one unit; each advance moves to the next scanline. Assumes rise > 0
// whenever adjust or advance is raised.
module efc_walker #(
    parameter int CW   = 10,
    parameter int YPIX = 512,
    localparam int PW  = CW + 2,
    localparam int RW  = CW + 3,
    localparam int YA  = $clog2(YPIX)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic                  adjust,
    input  logic                  advance,
    input  logic         [CW-1:0] lo_x,
    input  logic         [CW-1:0] lo_y,
    input  logic         [CW-1:0] rise,
    input  logic signed  [CW:0]   run,
    output logic signed  [PW-1:0] col,
    output logic         [YA-1:0] row,
    output logic                  settled,
    output logic                  final_line
);
    logic signed [PW-1:0] col_q;
    logic signed [RW-1:0] rem_q;
    logic signed [RW-1:0] run2_q;
    logic        [CW:0]   span2_q;
    logic        [CW-1:0] row_q;
    logic        [CW-1:0] left_q;
    logic signed [RW-1:0] span_ext;

    assign span_ext   = $signed({2'b00, span2_q});
    assign settled    = !rem_q[RW-1] && (rem_q < span_ext);
    assign final_line = (left_q == CW'(1));
    assign col        = col_q;
    assign row        = row_q[YA-1:0];

    // Load a new edge, normalise the remainder, or step one scanline.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q   <= '0;
            rem_q   <= '0;
            run2_q  <= '0;
            span2_q <= '0;
            row_q   <= '0;
            left_q  <= '0;
        end else if (load) begin
            col_q   <= $signed({2'b00, lo_x});
            rem_q   <= $signed({3'b000, rise}) + {{2{run[CW]}}, run};
            run2_q  <= {run[CW], run, 1'b0};
            span2_q <= {rise, 1'b0};
            row_q   <= lo_y;
            left_q  <= rise;
        end else if (adjust && !settled) begin
            if (rem_q[RW-1]) begin
                col_q <= col_q - PW'(1);
                rem_q <= rem_q + span_ext;
            end else begin
                col_q <= col_q + PW'(1);
                rem_q <= rem_q - span_ext;
            end
        end else if (advance) begin
            rem_q  <= rem_q + run2_q;
            row_q  <= row_q + CW'(1);
            left_q <= left_q - CW'(1);
        end
    end

    // R4: the walker never moves past the last scanline of the edge.
    assert_left_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (adjust || advance) |-> (left_q != '0));

    // R2: scanlines being walked stay inside the raster rows.
    assert_row_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (adjust || advance) |-> (row_q < CW'(YPIX)));
endmodule

// File: rtl/efc_port.sv
// Forms the working-plane address and read/write strobes from the walker
// position and the control state. Columns at or beyond XPIX are reported
// as not visible; negative columns clamp to zero. The write data is the
// inverse of the bit returned by the preceding read.
module efc_port
    import efc_pkg::*;
#(
    parameter int CW   = 10,
    parameter int XPIX = 512,
    parameter int YPIX = 512,
    localparam int PW  = CW + 2,
    localparam int XA  = $clog2(XPIX),
    localparam int YA  = $clog2(YPIX)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  efc_state_e             state,
    input  logic signed [PW-1:0]   col,
    input  logic        [YA-1:0]   row,
    input  logic                   rd_bit,
    output logic        [YA+XA-1:0] mem_addr,
    output logic                   mem_rd,
    output logic                   mem_wr,
    output logic                   mem_wbit,
    output logic                   visible
);
    localparam logic signed [PW-1:0] XLIM = PW'(XPIX);
    logic [XA-1:0] col_c;

    // Clamp the column and drive the single-bit memory port.
    always_comb begin
        visible  = (col < XLIM);
        col_c    = col[PW-1] ? '0 : col[XA-1:0];
        mem_addr = {row, col_c};
        mem_rd   = (state == ST_READ);
        mem_wr   = (state == ST_WRITE);
        mem_wbit = ~rd_bit;
    end

    // R3: each read is completed by a write to the same address next cycle.
    assert_rmw_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> (mem_wr && $stable(mem_addr)));

    // R10: read and write strobes never coincide.
    assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R10: the next toggle cannot begin in the cycle right after a write.
    assert_no_back_to_back_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> !mem_rd);
endmodule

// File: rtl/eflag_contour.sv
// Edge flag contour generator top. Accepts one edge per start while idle,
// walks it scanline by scanline and inverts one working-plane bit per
// scanline via read-invert-write. Assumes endpoints lie within the raster
// (0..XPIX, 0..YPIX) and a synchronous memory returning read data one cycle
// after the read strobe.
module eflag_contour
    import efc_pkg::*;
#(
    parameter int XPIX = 512,
    parameter int YPIX = 512,
    localparam int CW  = $clog2(((XPIX > YPIX) ? XPIX : YPIX) + 1),
    localparam int XA  = $clog2(XPIX),
    localparam int YA  = $clog2(YPIX),
    localparam int PW  = CW + 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [CW-1:0]       x0,
    input  logic [CW-1:0]       y0,
    input  logic [CW-1:0]       x1,
    input  logic [CW-1:0]       y1,
    output logic                busy,
    output logic                done,
    output logic [YA+XA-1:0]    mem_addr,
    output logic                mem_rd,
    output logic                mem_wr,
    output logic                mem_wbit,
    input  logic                mem_rbit
);
    efc_state_e            state, nxt;
    logic [CW-1:0]         lo_x, lo_y, rise;
    logic signed [CW:0]    run;
    logic                  flat;
    logic                  load, adjust, advance;
    logic signed [PW-1:0]  col;
    logic [YA-1:0]         row;
    logic                  settled, final_line, visible;

    efc_order #(.CW(CW)) u_order (
        .x0(x0), .y0(y0), .x1(x1), .y1(y1),
        .lo_x(lo_x), .lo_y(lo_y), .rise(rise), .run(run), .flat(flat)
    );

    efc_walker #(.CW(CW), .YPIX(YPIX)) u_walker (
        .clk(clk), .rst_n(rst_n),
        .load(load), .adjust(adjust), .advance(advance),
        .lo_x(lo_x), .lo_y(lo_y), .rise(rise), .run(run),
        .col(col), .row(row), .settled(settled), .final_line(final_line)
    );

    efc_port #(.CW(CW), .XPIX(XPIX), .YPIX(YPIX)) u_port (
        .clk(clk), .rst_n(rst_n), .state(state),
        .col(col), .row(row), .rd_bit(mem_rbit),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wbit(mem_wbit), .visible(visible)
    );

    // Control state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Next-state and walker controls.
    always_comb begin
        nxt     = state;
        load    = 1'b0;
        adjust  = 1'b0;
        advance = 1'b0;
        unique case (state)
            ST_IDLE: if (start) begin
                load = 1'b1;
                nxt  = flat ? ST_FIN : ST_NORM;
            end
            ST_NORM: begin
                if (settled) nxt = visible ? ST_READ : ST_STEP;
                else         adjust = 1'b1;
            end
            ST_READ:  nxt = ST_WRITE;
            ST_WRITE: nxt = ST_STEP;
            ST_STEP: begin
                if (final_line) nxt = ST_FIN;
                else begin
                    advance = 1'b1;
                    nxt     = ST_NORM;
                end
            end
            ST_FIN:   nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    assign busy = (state != ST_IDLE);
    assign done = (state == ST_FIN);

    // R8: completion is a single-cycle pulse followed by idle.
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R6: a flat edge completes in the cycle after it is accepted.
    assert_flat_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && (y0 == y1)) |=> done);

    // R2: a bit is only read once the column is settled and on screen.
    assert_read_settled_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> (settled && visible));
endmodule

// File: tb/eflag_contour_bench.sv
`timescale 1ns/1ps
module eflag_contour_bench;
    localparam int XPIX = 512, YPIX = 512, CW = 10, XA = 9, YA = 9, AW = 18;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [CW-1:0] x0 = '0, y0 = '0, x1 = '0, y1 = '0;
    logic busy, done, mem_rd, mem_wr, mem_wbit;
    logic mem_rbit = 1'b0;
    logic [AW-1:0] mem_addr;

    logic [XPIX-1:0] plane [YPIX];
    int n_cmp = 0, n_bad = 0, cycles = 0, last_rd = -1;
    int got_q[$];
    int exp_q[$];

    eflag_contour u_eflag_contour (
        .clk(clk), .rst_n(rst_n), .start(start),
        .x0(x0), .y0(y0), .x1(x1), .y1(y1),
        .busy(busy), .done(done),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wbit(mem_wbit), .mem_rbit(mem_rbit)
    );

    always #10 clk = ~clk;

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Working-plane model with one-cycle read latency.
    always @(posedge clk) begin
        if (mem_rd) mem_rbit <= plane[mem_addr[AW-1:XA]][mem_addr[XA-1:0]];
        if (mem_wr) plane[mem_addr[AW-1:XA]][mem_addr[XA-1:0]] <= mem_wbit;
    end

    // Port monitor: pairs reads with writes and logs toggles (R3).
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_rd) last_rd = int'(mem_addr);
            if (mem_wr) begin
                check(int'(mem_addr) == last_rd, "R3", "write address", int'(mem_addr), last_rd);
                check(mem_wbit == ~plane[mem_addr[AW-1:XA]][mem_addr[XA-1:0]], "R3", "inverted bit",
                      int'(mem_wbit), int'(~plane[mem_addr[AW-1:XA]][mem_addr[XA-1:0]]));
                got_q.push_back(int'(mem_addr));
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, 190000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // Expected toggle addresses from the half-pixel crossing rule (R2, R7).
    task automatic build_exp(int ax, int ay, int bx, int by);
        int xa, ya, xb, yb, dy, dx, n, d, p;
        exp_q.delete();
        if (by < ay) begin xa = bx; ya = by; xb = ax; yb = ay; end
        else         begin xa = ax; ya = ay; xb = bx; yb = by; end
        dy = yb - ya; dx = xb - xa;
        for (int k = 0; k < dy; k++) begin
            n = 2*dy*xa + dy + dx*(2*k + 1);
            d = 2*dy;
            p = n / d;
            if (n < 0 && (n % d) != 0) p = p - 1;
            if (p < 0) p = 0;
            if (p < XPIX) exp_q.push_back((ya + k)*XPIX + p);
        end
    endtask

    task automatic run_edge(int ax, int ay, int bx, int by, string tag, int poke);
        build_exp(ax, ay, bx, by);
        got_q.delete();
        @(negedge clk);
        x0 = CW'(ax); y0 = CW'(ay); x1 = CW'(bx); y1 = CW'(by);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (ay == by) begin
            check(done == 1'b1, "R6", {tag, " flat done"}, int'(done), 1);
            check(!mem_rd && !mem_wr, "R6", {tag, " flat access"}, int'(mem_rd | mem_wr), 0);
        end else begin
            check(busy == 1'b1, "R9", {tag, " busy"}, int'(busy), 1);
            if (poke > 0) begin
                repeat (poke) @(negedge clk);
                x0 = CW'(7); y0 = CW'(0); x1 = CW'(400); y1 = CW'(300);
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
            end
            for (int g = 0; g < 20000 && !done; g++) @(negedge clk);
        end
        check(done == 1'b1, "R8", {tag, " done seen"}, int'(done), 1);
        @(negedge clk);
        check(done == 1'b0 && busy == 1'b0, "R8", {tag, " done pulse"}, int'({busy, done}), 0);
        check(got_q.size() == exp_q.size(), "R4", {tag, " toggle count"}, got_q.size(), exp_q.size());
        for (int i = 0; i < got_q.size() && i < exp_q.size(); i++)
            check(got_q[i] == exp_q[i], "R2", {tag, " toggle address"}, got_q[i], exp_q[i]);
    endtask

    task automatic clear_plane();
        for (int r = 0; r < YPIX; r++) plane[r] = '0;
    endtask

    function automatic int plane_ones();
        int s = 0;
        for (int r = 0; r < YPIX; r++) s += $countones(plane[r]);
        return s;
    endfunction

    initial begin
        int ax, ay, bx, by;
        clear_plane();
        repeat (3) @(negedge clk);
        check(!busy && !done && !mem_rd && !mem_wr, "R1", "in reset",
              int'({busy, done, mem_rd, mem_wr}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !mem_rd && !mem_wr, "R1", "after reset",
              int'({busy, done, mem_rd, mem_wr}), 0);

        run_edge(0, 2, 8, 7, "R2 slanted", 0);
        run_edge(8, 7, 0, 2, "R5 reversed", 0);
        run_edge(3, 4, 100, 4, "R6 flat", 0);
        run_edge(5, 0, 5, 3, "R2 vertical", 0);
        run_edge(512, 0, 512, 4, "R7 right border", 0);
        run_edge(511, 10, 512, 12, "R7 partial", 0);
        run_edge(0, 0, 512, 1, "R2 shallow", 0);
        run_edge(400, 50, 2, 51, "R2 shallow left", 0);
        run_edge(0, 511, 512, 512, "R2 top row", 0);
        run_edge(20, 30, 200, 90, "R9 ignored start", 4);

        clear_plane();
        run_edge(10, 20, 300, 200, "R3 first pass", 0);
        check(plane_ones() == exp_q.size(), "R3", "ones after one pass", plane_ones(), exp_q.size());
        run_edge(300, 200, 10, 20, "R3 second pass", 0);
        check(plane_ones() == 0, "R3", "plane restored", plane_ones(), 0);

        void'($urandom(32'h5eed));
        for (int t = 0; t < 24; t++) begin
            ax = int'($urandom % 513); ay = int'($urandom % 513);
            bx = int'($urandom % 513);
            by = (t % 5 == 0) ? ay : int'($urandom % 513);
            run_edge(ax, ay, bx, by, "R4 random", 0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule